// File: doc/BRIEF.md
# Serial Transmit Engine with Stick Parity

This block turns a parallel word into an asynchronous serial frame on a single line. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A word enters through a valid/ready handshake. Its frame settings are taken in at the same clock edge: word length, parity enable, even select, stick select and stop count. An external baud tick enable paces every bit, and the line rests high between frames.

Parity can be computed as even or odd, or forced to a fixed level (stick parity). The longest word-length code carries no parity at all. A break input pulls the line low without stopping the sequencer, so the frame timing underneath carries on. An active-low request-to-send output follows a request bit. The break and request inputs pass through one register, which resets to zero.

Top module: `uart_tx_stick`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_ready` is 1, `txd` is 1 and `rts_n` is 1. The break flop, the request flop and the captured settings are all 0.
- R2: A word is accepted at a clock edge where `tx_valid` and `tx_ready` are both 1, and `tx_ready` is 0 from the next cycle. While `tx_ready` is 0, `tx_valid` and `tx_data` are ignored. `tx_ready` returns to 1 in the cycle after the tick edge that ends the last stop bit.
- R3: After acceptance the line stays high until the next edge with `baud_tick` at 1. The start bit (0) begins there. Every later bit lasts from one tick edge to the next, and data bits go out least significant first.
- R4: `cfg_wlen` selects DATA_W-2 data bits for 2'b00, DATA_W-1 for 2'b01 and 2'b11, and DATA_W for 2'b10. At the default DATA_W=9 that is 7, 8, 8 and 9 bits.
- R5: With `cfg_par_en` at 0, the frame holds no parity bit: the stop bits follow the last data bit directly.
- R6: With parity enabled and `cfg_stick` at 0, the parity bit makes the number of ones in data plus parity even when `cfg_even` is 1, and odd when `cfg_even` is 0.
- R7: With parity and `cfg_stick` both at 1, the parity bit is 1 when `cfg_even` is 0 and 0 when `cfg_even` is 1, whatever the data.
- R8: With `cfg_par_en` at 0, the values of `cfg_even` and `cfg_stick` do not change the frame.
- R9: With `cfg_wlen` at 2'b10, `cfg_par_en` is ignored and no parity bit is sent.
- R10: `cfg_two_stop` at 0 gives one stop bit and at 1 gives two. Stop bits are high.
- R11: In the cycle after `cfg_break` is sampled at 1, `txd` is 0, and it stays 0 as long as `cfg_break` stays 1. The sequencer keeps its timing, so after release the line shows the bit the undisturbed frame would show.
- R12: `rts_n` equals the inverse of `cfg_rts_req` as sampled at the previous clock edge.
- R13: The settings and data sampled at acceptance hold for the whole frame. Changes to the setting inputs during a frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| tx_valid | input | 1 | A word is offered |
| tx_ready | output | 1 | Engine idle, word can be taken |
| tx_data | input | DATA_W | Word to send, bit 0 first |
| cfg_wlen | input | 2 | Word-length code |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_even | input | 1 | Even parity select, or stick level select |
| cfg_stick | input | 1 | Force parity to a fixed level |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_break | input | 1 | Hold the line low |
| cfg_rts_req | input | 1 | Request-to-send bit |
| txd | output | 1 | Serial line |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The bench builds the block at DATA_W=9 and LINE_REG=0. With these values the four length codes give 7, 8 and 9 bit words, so the 9-bit code, where parity is suppressed, can be tested next to the 8-bit codes, where parity is present. With the combinational line path, the line and `tx_ready` can be compared cycle for cycle against a queue model that builds each frame from the sampled settings. The tick spacing is changed from four cycles to one, which brings the cases where acceptance and a tick land on the same edge within reach.

// File: rtl/uart_tx_stick_pkg.sv
package uart_tx_stick_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_START = 3'd2,
      ST_DATA  = 3'd3,
      ST_PAR   = 3'd4,
      ST_STOP  = 3'd5
   } tx_state_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       par_en;
      logic       even;
      logic       stick;
      logic       two_stop;
   } frame_cfg_t;

   localparam logic [1:0] WLEN_SHORT = 2'b00;
   localparam logic [1:0] WLEN_MID   = 2'b01;
   localparam logic [1:0] WLEN_LONG  = 2'b10;
   localparam logic [1:0] WLEN_ALT   = 2'b11;

endpackage

// File: rtl/utx_width_dec.sv
module utx_width_dec
   import uart_tx_stick_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int CNT_W  = 4
) (
   input  logic [1:0]       wlen,
   input  logic             par_req,
   output logic [CNT_W-1:0] nbits,
   output logic             par_on
);

   localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(DATA_W - 2);
   localparam logic [CNT_W-1:0] N_MID   = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(DATA_W);

   always_comb begin
      case (wlen)
         WLEN_SHORT: nbits = N_SHORT;
         WLEN_MID:   nbits = N_MID;
         WLEN_LONG:  nbits = N_LONG;
         default:    nbits = N_MID;
      endcase
   end

   // longest code carries no parity bit
   assign par_on = par_req & (wlen != WLEN_LONG);

endmodule

// File: rtl/utx_parity.sv
module utx_parity #(
   parameter int DATA_W = 9,
   parameter int CNT_W  = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  nbits,
   input  logic              even,
   input  logic              stick,
   output logic              par_bit
);

   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_mask
         assign mask[gi] = (CNT_W'(gi) < nbits);
      end
   endgenerate

   assign ones_odd = ^(data & mask);

   always_comb begin
      if (stick)
         par_bit = ~even;
      else if (even)
         par_bit = ones_odd;
      else
         par_bit = ~ones_odd;
   end

endmodule

// File: rtl/utx_seq.sv
module utx_seq
   import uart_tx_stick_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  frame_cfg_t        cfg_in,
   input  logic [CNT_W-1:0]  nbits,
   input  logic              par_on,
   input  logic              par_bit,
   output logic              tx_ready,
   output logic              line_bit,
   output logic [DATA_W-1:0] data_q,
   output frame_cfg_t        cfg_q
);

   tx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_idx;
   logic             stop2;
   logic             data_sel;

   assign last_idx = nbits - CNT_W'(1);
   assign tx_ready = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         data_q <= '0;
         cfg_q  <= '0;
         cnt    <= '0;
         stop2  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (tx_valid) begin
                  data_q <= tx_data;
                  cfg_q  <= cfg_in;
                  state  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (baud_tick) state <= ST_START;
            end
            ST_START: begin
               if (baud_tick) begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end
            end
            ST_DATA: begin
               if (baud_tick) begin
                  if (cnt == last_idx) begin
                     state <= par_on ? ST_PAR : ST_STOP;
                     stop2 <= 1'b0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            ST_PAR: begin
               if (baud_tick) begin
                  state <= ST_STOP;
                  stop2 <= 1'b0;
               end
            end
            ST_STOP: begin
               if (baud_tick) begin
                  if (cfg_q.two_stop && !stop2)
                     stop2 <= 1'b1;
                  else
                     state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      data_sel = 1'b1;
      for (int i = 0; i < DATA_W; i++) begin
         if (cnt == CNT_W'(i)) data_sel = data_q[i];
      end
   end

   always_comb begin
      case (state)
         ST_START: line_bit = 1'b0;
         ST_DATA:  line_bit = data_sel;
         ST_PAR:   line_bit = par_bit;
         default:  line_bit = 1'b1;
      endcase
   end

endmodule

// File: rtl/utx_line.sv
module utx_line #(
   parameter bit LINE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_bit,
   input  logic brk_in,
   input  logic rts_in,
   output logic txd,
   output logic rts_n
);

   logic brk_q;
   logic rts_q;
   logic line_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q <= 1'b0;
         rts_q <= 1'b0;
      end else begin
         brk_q <= brk_in;
         rts_q <= rts_in;
      end
   end

   generate
      if (LINE_REG) begin : g_line_reg
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= line_bit;
         end
         assign line_v = line_q;
      end else begin : g_line_comb
         assign line_v = line_bit;
      end
   endgenerate

   // break overrides the line only; sequencer is untouched
   assign txd   = brk_q ? 1'b0 : line_v;
   assign rts_n = ~rts_q;

endmodule

// File: rtl/uart_tx_stick.sv
module uart_tx_stick
   import uart_tx_stick_pkg::*;
#(
   parameter int DATA_W   = 9,
   parameter bit LINE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_even,
   input  logic              cfg_stick,
   input  logic              cfg_two_stop,
   input  logic              cfg_break,
   input  logic              cfg_rts_req,
   output logic              txd,
   output logic              rts_n
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 3 || DATA_W > 32) begin : g_bad_width
         $error("uart_tx_stick: DATA_W must lie in 3..32");
      end
   endgenerate

   frame_cfg_t        cfg_in;
   frame_cfg_t        cfg_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  nbits;
   logic              par_on;
   logic              par_bit;
   logic              line_bit;

   assign cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en, even: cfg_even,
                     stick: cfg_stick, two_stop: cfg_two_stop};

   utx_width_dec #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wdec (
      .wlen    (cfg_q.wlen),
      .par_req (cfg_q.par_en),
      .nbits   (nbits),
      .par_on  (par_on)
   );

   utx_parity #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_par (
      .data    (data_q),
      .nbits   (nbits),
      .even    (cfg_q.even),
      .stick   (cfg_q.stick),
      .par_bit (par_bit)
   );

   utx_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .cfg_in    (cfg_in),
      .nbits     (nbits),
      .par_on    (par_on),
      .par_bit   (par_bit),
      .tx_ready  (tx_ready),
      .line_bit  (line_bit),
      .data_q    (data_q),
      .cfg_q     (cfg_q)
   );

   utx_line #(.LINE_REG(LINE_REG)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_bit (line_bit),
      .brk_in   (cfg_break),
      .rts_in   (cfg_rts_req),
      .txd      (txd),
      .rts_n    (rts_n)
   );

endmodule

// File: rtl/uart_tx_stick_chk.sv
module uart_tx_stick_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_valid,
   input logic tx_ready,
   input logic cfg_break,
   input logic cfg_rts_req,
   input logic txd,
   input logic rts_n
);

   logic up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_q <= 1'b0;
      else        up_q <= 1'b1;
   end

   p_break_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $past(cfg_break)) |-> !txd);

   p_rts_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      up_q |-> (rts_n == !$past(cfg_rts_req)));

   p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   p_ready_back_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $rose(tx_ready)) |-> $past(baud_tick));

   p_idle_line_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && tx_ready && !$past(cfg_break)) |-> txd);

   p_reset_rts_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_q) |-> (rts_n && tx_ready));

endmodule

bind uart_tx_stick uart_tx_stick_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick   (baud_tick),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .cfg_break   (cfg_break),
   .cfg_rts_req (cfg_rts_req),
   .txd         (txd),
   .rts_n       (rts_n)
);

// File: tb/uart_tx_stick_bench.sv
module uart_tx_stick_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [8:0] tx_data = '0;
   logic [1:0] cfg_wlen = 2'b00;
   logic       cfg_par_en = 1'b0;
   logic       cfg_even = 1'b0;
   logic       cfg_stick = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_break = 1'b0;
   logic       cfg_rts_req = 1'b0;
   logic       txd;
   logic       rts_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int tick_div = 4;
   int tick_cnt = 0;
   string cur_req = "R1";
   bit cmp_on = 1'b0;

   // reference model state
   bit m_busy = 0;
   bit m_wait = 0;
   bit m_brk = 0;
   bit m_rts = 0;
   bit m_q[$];

   always #10 clk = ~clk;   // 50 MHz

   uart_tx_stick u_uart_tx_stick (
      .clk          (clk),
      .rst_n        (rst_n),
      .baud_tick    (baud_tick),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .tx_data      (tx_data),
      .cfg_wlen     (cfg_wlen),
      .cfg_par_en   (cfg_par_en),
      .cfg_even     (cfg_even),
      .cfg_stick    (cfg_stick),
      .cfg_two_stop (cfg_two_stop),
      .cfg_break    (cfg_break),
      .cfg_rts_req  (cfg_rts_req),
      .txd          (txd),
      .rts_n        (rts_n)
   );

   // build the expected frame from the requirement text
   task automatic build_frame();
      int n;
      int ones;
      bit p;
      m_q.delete();
      n = (cfg_wlen == 2'b00) ? 7 : (cfg_wlen == 2'b10) ? 9 : 8;   // R4
      m_q.push_back(1'b0);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         m_q.push_back(tx_data[i]);
         if (tx_data[i]) ones++;
      end
      if (cfg_par_en && cfg_wlen != 2'b10) begin                   // R5 R9
         if (cfg_stick) p = !cfg_even;                             // R7
         else if (cfg_even) p = (ones % 2) == 1;                   // R6
         else p = (ones % 2) == 0;
         m_q.push_back(p);
      end
      m_q.push_back(1'b1);
      if (cfg_two_stop) m_q.push_back(1'b1);                       // R10
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_wait = 0; m_brk = 0; m_rts = 0;
         m_q.delete();
      end else begin
         m_brk = cfg_break;
         m_rts = cfg_rts_req;
         if (!m_busy) begin
            if (tx_valid) begin
               build_frame();
               m_busy = 1; m_wait = 1;
            end
         end else if (baud_tick) begin
            if (m_wait) m_wait = 0;
            else begin
               void'(m_q.pop_front());
               if (m_q.size() == 0) m_busy = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      bit e_txd;
      bit e_rdy;
      bit e_rts;
      if (cmp_on) begin
         e_rdy = !m_busy;
         e_rts = !m_rts;
         e_txd = m_brk ? 1'b0 : ((m_busy && !m_wait) ? m_q[0] : 1'b1);
         checks++;
         if (txd !== e_txd || tx_ready !== e_rdy || rts_n !== e_rts) begin
            errors++;
            $display("FAIL %s cycle %0d txd/ready/rts_n actual %b%b%b expected %b%b%b",
                     cur_req, cycles, txd, tx_ready, rts_n, e_txd, e_rdy, e_rts);
         end
      end
   end

   // baud tick generator
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         tick_cnt = 0; baud_tick = 1'b0;
      end else begin
         tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
         baud_tick = (tick_cnt == 0);
      end
   end

   task automatic set_cfg(input [1:0] wl, input bit pe, input bit ev,
                          input bit st, input bit ts);
      cfg_wlen = wl; cfg_par_en = pe; cfg_even = ev; cfg_stick = st; cfg_two_stop = ts;
   endtask

   task automatic send(input [8:0] d, input [1:0] wl, input bit pe, input bit ev,
                       input bit st, input bit ts);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data = d;
      set_cfg(wl, pe, ev, st, ts);
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      cmp_on = 1'b1;
      // R1: reset state
      cur_req = "R1";
      checks++;
      if (tx_ready !== 1'b1 || txd !== 1'b1 || rts_n !== 1'b1) begin
         errors++;
         $display("FAIL R1 reset actual %b%b%b expected 111", tx_ready, txd, rts_n);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      cur_req = "R3";  send(9'h0A5, 2'b01, 0, 0, 0, 0); wait_idle();
      cur_req = "R4";  send(9'h17F, 2'b00, 0, 0, 0, 0); wait_idle();
      cur_req = "R4";  send(9'h0C3, 2'b11, 0, 0, 0, 0); wait_idle();
      cur_req = "R5";  send(9'h055, 2'b01, 0, 0, 0, 0); wait_idle();
      cur_req = "R6";  send(9'h0B4, 2'b01, 1, 1, 0, 0); wait_idle();
      cur_req = "R6";  send(9'h0B4, 2'b01, 1, 0, 0, 0); wait_idle();
      cur_req = "R6";  send(9'h1F1, 2'b00, 1, 1, 0, 0); wait_idle();
      cur_req = "R7";  send(9'h0B4, 2'b01, 1, 0, 1, 0); wait_idle();
      cur_req = "R7";  send(9'h0B5, 2'b01, 1, 1, 1, 0); wait_idle();
      cur_req = "R8";  send(9'h0B4, 2'b01, 0, 1, 1, 0); wait_idle();
      cur_req = "R9";  send(9'h1C3, 2'b10, 1, 1, 0, 0); wait_idle();
      cur_req = "R10"; send(9'h0F0, 2'b01, 1, 0, 0, 1); wait_idle();

      // R11: break in the middle of a frame
      cur_req = "R11";
      send(9'h05A, 2'b01, 1, 1, 0, 1);
      repeat (10) @(negedge clk);
      cfg_break = 1'b1;
      repeat (9) @(negedge clk);
      cfg_break = 1'b0;
      wait_idle();

      // R12: request bit toggling
      cur_req = "R12";
      cfg_rts_req = 1'b1; repeat (3) @(negedge clk);
      cfg_rts_req = 1'b0; repeat (2) @(negedge clk);
      cfg_rts_req = 1'b1; @(negedge clk);

      // R13 and R2: change settings and offer a word mid-frame
      cur_req = "R13";
      send(9'h133, 2'b01, 1, 0, 0, 0);
      repeat (6) @(negedge clk);
      set_cfg(2'b10, 0, 1, 1, 1);
      tx_data = 9'h0FF;
      cur_req = "R2";
      tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
      wait_idle();

      // R2: valid held high for back-to-back frames with tick on every cycle
      tick_div = 1;
      tx_data = 9'h0E1; set_cfg(2'b01, 1, 1, 0, 0);
      tx_valid = 1'b1;
      repeat (30) @(negedge clk);
      tx_valid = 1'b0;
      wait_idle();
      tick_div = 4;
      cur_req = "R3"; send(9'h02C, 2'b11, 1, 0, 1, 1); wait_idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      while (cycles < 150000) @(negedge clk);
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected finish earlier", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule